// File: doc/BRIEF.md
# Serial-Function I/O Port Multiplexer

This block is a six-bit general-purpose I/O port whose pins can be lent to two serial channels. Software programs an output latch, a per-bit direction register, a per-bit function register and a one-bit receive-source select over a small synchronous register bus. Each pin drives the pad with an output value and an output enable, and reads back a pad input level.

Four pins have serial roles. Pins 1 and 4 carry receive data for channels 0 and 1. Pins 2 and 5 carry clear-to-send or serial clock for channels 0 and 1, and the clock can come in or go out. When a pin serves a serial channel, its latch bit stops being an output value and becomes a polarity control: the signal passing through the pin is XORed with it. For channel 0, receive data can be taken from pin 1 or from an alternate receive input that comes from elsewhere on the chip. The same latch-bit inversion is applied after that choice.

The channel logic and the pad cells sit outside this block. All serial-side paths are combinational. Only the registers hold state.

Top module: `sio_port_mux`

## Requirements
- R1: An asynchronous active-low reset sets every latch bit to 1 and clears the direction, function and alternate-select registers, so every pin starts undriven.
- R2: A write with `wr_en` high updates the register chosen by `addr` at the clock edge: 0 = output latch, 1 = direction, 2 = function, 3 = alternate select (held in `wdata[0]`). Reads of addresses 1 and 2 return the stored register, and a read of address 3 returns the select in bit 0 with zeros above it.
- R3: A read of address 0 returns, per bit, the latch value when the direction bit is 1 and the pad input level when it is 0.
- R4: `pin_oe` equals the direction register bit for bit (1 = output).
- R5: On pins 0, 1, 3 and 4, and on pins 2 and 5 while their function bit is 0, `pin_out` equals the latch bit.
- R6: On pin 2 (channel 0) or pin 5 (channel 1) with its function bit at 1, `pin_out` equals that channel's `sclk_out` XOR the pin's latch bit.
- R7: `ch_rx[1]` equals `pin_in[4]` XOR latch bit 4.
- R8: `ch_rx[0]` equals either `pin_in[1]` (select = 0) or `alt_rx0_i` (select = 1), XOR latch bit 1.
- R9: For channel k, `ch_cts[k]` and `ch_sclk_in[k]` both equal the level of pin 2 (k = 0) or pin 5 (k = 1) XOR that pin's latch bit, whatever the direction and function settings.
- R10: Function bits on pins 0, 1, 3 and 4 have no effect on `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for writes and reads |
| wdata | input | 6 | Write data |
| rdata | output | 6 | Read data for `addr` (combinational) |
| pin_in | input | 6 | Pad input levels |
| pin_out | output | 6 | Pad output values |
| pin_oe | output | 6 | Pad output enables |
| alt_rx0_i | input | 1 | Alternate receive input for channel 0 |
| sclk_out | input | 2 | Serial clock from channels 1:0 to be driven out |
| ch_rx | output | 2 | Receive data to channels 1:0 |
| ch_cts | output | 2 | Clear-to-send to channels 1:0 |
| ch_sclk_in | output | 2 | Serial clock input to channels 1:0 |

## Verification
A register write changes the outputs that depend on it one edge later. The new value shows up on `pin_oe`, `pin_out`, the channel outputs and `rdata` right after the writing edge. Every path from a pad, `sclk_out`, `alt_rx0_i` or `addr` to an output is combinational and is due in the same cycle. The bench therefore changes inputs on the falling edge and performs each write across one rising edge. It compares all outputs a few nanoseconds after the stimulus settles, well away from the next rising edge, and steps `addr` through all four values to read the registers.

// File: rtl/sio_port_pkg.sv
package sio_port_pkg;
   typedef enum logic [1:0] {
      REG_LATCH = 2'd0,
      REG_DIR   = 2'd1,
      REG_FUNC  = 2'd2,
      REG_ALT   = 2'd3
   } sio_reg_e;
endpackage

// File: rtl/sio_port_regs.sv
module sio_port_regs
   import sio_port_pkg::*;
#(
   parameter int PORT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [PORT_W-1:0] wdata,
   output logic [PORT_W-1:0] lat_q,
   output logic [PORT_W-1:0] dir_q,
   output logic [PORT_W-1:0] fn_q,
   output logic              alt_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '1;
         dir_q <= '0;
         fn_q  <= '0;
         alt_q <= 1'b0;
      end else if (wr_en) begin
         case (sio_reg_e'(addr))
            REG_LATCH: lat_q <= wdata;
            REG_DIR:   dir_q <= wdata;
            REG_FUNC:  fn_q  <= wdata;
            REG_ALT:   alt_q <= wdata[0];
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/sio_port_pin.sv
module sio_port_pin #(
   parameter bit HAS_CLK = 1'b0
) (
   input  logic dir,
   input  logic fn,
   input  logic lat,
   input  logic pad_in,
   input  logic clk_src,
   output logic pad_out,
   output logic pad_oe,
   output logic rd_bit
);
   logic use_clk;
   always_comb begin
      use_clk = HAS_CLK && fn;
      pad_out = use_clk ? (clk_src ^ lat) : lat;
      pad_oe  = dir;
      rd_bit  = dir ? lat : pad_in;
   end
endmodule

// File: rtl/sio_port_route.sv
module sio_port_route (
   input  logic       rx0_pin,
   input  logic       rx1_pin,
   input  logic       ck0_pin,
   input  logic       ck1_pin,
   input  logic       alt_rx0,
   input  logic       alt_sel,
   input  logic [3:0] inv,      // {ck1, ck0, rx1, rx0} polarity bits
   output logic [1:0] rx,
   output logic [1:0] cts,
   output logic [1:0] sclk_in
);
   logic rx0_src;
   always_comb begin
      rx0_src    = alt_sel ? alt_rx0 : rx0_pin;
      rx[0]      = rx0_src ^ inv[0];
      rx[1]      = rx1_pin ^ inv[1];
      cts[0]     = ck0_pin ^ inv[2];
      cts[1]     = ck1_pin ^ inv[3];
      sclk_in    = cts;
   end
endmodule

// File: rtl/sio_port_mux.sv
module sio_port_mux
   import sio_port_pkg::*;
#(
   parameter int PORT_W  = 6,
   parameter int RX0_BIT = 1,
   parameter int RX1_BIT = 4,
   parameter int CK0_BIT = 2,
   parameter int CK1_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [PORT_W-1:0] wdata,
   output logic [PORT_W-1:0] rdata,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe,
   input  logic              alt_rx0_i,
   input  logic [1:0]        sclk_out,
   output logic [1:0]        ch_rx,
   output logic [1:0]        ch_cts,
   output logic [1:0]        ch_sclk_in
);
   if (PORT_W < 2) begin : g_bad_width
      $error("sio_port_mux: PORT_W must be at least 2");
   end
   if (RX0_BIT >= PORT_W || RX1_BIT >= PORT_W || CK0_BIT >= PORT_W || CK1_BIT >= PORT_W) begin : g_bad_bit
      $error("sio_port_mux: serial pin index outside the port");
   end
   if (CK0_BIT == CK1_BIT || RX0_BIT == RX1_BIT) begin : g_bad_share
      $error("sio_port_mux: two channels mapped to one pin");
   end

   logic [PORT_W-1:0] lat_q, dir_q, fn_q, rd_vec;
   logic              alt_q;

   sio_port_regs #(.PORT_W(PORT_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .lat_q (lat_q),
      .dir_q (dir_q),
      .fn_q  (fn_q),
      .alt_q (alt_q)
   );

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      localparam bit IS_CK  = (i == CK0_BIT) || (i == CK1_BIT);
      localparam int CK_CH  = (i == CK1_BIT) ? 1 : 0;
      sio_port_pin #(.HAS_CLK(IS_CK)) u_pin (
         .dir     (dir_q[i]),
         .fn      (fn_q[i]),
         .lat     (lat_q[i]),
         .pad_in  (pin_in[i]),
         .clk_src (sclk_out[CK_CH]),
         .pad_out (pin_out[i]),
         .pad_oe  (pin_oe[i]),
         .rd_bit  (rd_vec[i])
      );
   end

   sio_port_route u_route (
      .rx0_pin (pin_in[RX0_BIT]),
      .rx1_pin (pin_in[RX1_BIT]),
      .ck0_pin (pin_in[CK0_BIT]),
      .ck1_pin (pin_in[CK1_BIT]),
      .alt_rx0 (alt_rx0_i),
      .alt_sel (alt_q),
      .inv     ({lat_q[CK1_BIT], lat_q[CK0_BIT], lat_q[RX1_BIT], lat_q[RX0_BIT]}),
      .rx      (ch_rx),
      .cts     (ch_cts),
      .sclk_in (ch_sclk_in)
   );

   always_comb begin
      case (sio_reg_e'(addr))
         REG_LATCH: rdata = rd_vec;
         REG_DIR:   rdata = dir_q;
         REG_FUNC:  rdata = fn_q;
         default:   rdata = {{(PORT_W-1){1'b0}}, alt_q};
      endcase
   end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk
   import sio_port_pkg::*;
#(
   parameter int PORT_W  = 6,
   parameter int RX1_BIT = 4,
   parameter int CK0_BIT = 2,
   parameter int CK1_BIT = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [PORT_W-1:0] wdata,
   input logic [PORT_W-1:0] pin_in,
   input logic [PORT_W-1:0] pin_out,
   input logic [PORT_W-1:0] pin_oe,
   input logic [1:0]        sclk_out,
   input logic              rx1,
   input logic [1:0]        ch_cts,
   input logic [PORT_W-1:0] lat_q,
   input logic [PORT_W-1:0] fn_q
);
   localparam logic [PORT_W-1:0] CK_MASK    = (PORT_W'(1) << CK0_BIT) | (PORT_W'(1) << CK1_BIT);
   localparam logic [PORT_W-1:0] PLAIN_MASK = ~CK_MASK;

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (pin_oe == '0 && lat_q == '1)); // R1
   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_DIR) |=> (pin_oe == $past(wdata))); // R4
   AST_PLAIN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_LATCH) |=> (((pin_out ^ $past(wdata)) & PLAIN_MASK) == '0)); // R5
   AST_CLK0_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe[CK0_BIT] && fn_q[CK0_BIT]) |-> (pin_out[CK0_BIT] == (sclk_out[0] ^ lat_q[CK0_BIT]))); // R6
   AST_CLK1_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe[CK1_BIT] && fn_q[CK1_BIT]) |-> (pin_out[CK1_BIT] == (sclk_out[1] ^ lat_q[CK1_BIT]))); // R6
   AST_RX1_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      rx1 == (pin_in[RX1_BIT] ^ lat_q[RX1_BIT])); // R7
   AST_CTS_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cts == {pin_in[CK1_BIT] ^ lat_q[CK1_BIT], pin_in[CK0_BIT] ^ lat_q[CK0_BIT]}); // R9
endmodule

bind sio_port_mux sio_port_chk #(
   .PORT_W (PORT_W),
   .RX1_BIT(RX1_BIT),
   .CK0_BIT(CK0_BIT),
   .CK1_BIT(CK1_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .pin_in   (pin_in),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .sclk_out (sclk_out),
   .rx1      (ch_rx[1]),
   .ch_cts   (ch_cts),
   .lat_q    (lat_q),
   .fn_q     (fn_q)
);

// File: tb/sim_sio_port_mux.sv
module sim_sio_port_mux;
   localparam int W = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   addr = 2'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic [W-1:0] pin_in = '0;
   logic [W-1:0] pin_out, pin_oe;
   logic         alt_rx0_i = 1'b0;
   logic [1:0]   sclk_out = 2'b00;
   logic [1:0]   ch_rx, ch_cts, ch_sclk_in;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [W-1:0] m_lat = '1, m_dir = '0, m_fn = '0;
   logic         m_alt = 1'b0;

   always #5 clk = ~clk;

   sio_port_mux u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .alt_rx0_i(alt_rx0_i), .sclk_out(sclk_out), .ch_rx(ch_rx),
      .ch_cts(ch_cts), .ch_sclk_in(ch_sclk_in)
   );

   function automatic logic [W-1:0] exp_out();
      logic [W-1:0] v = m_lat;
      if (m_fn[2]) v[2] = sclk_out[0] ^ m_lat[2];
      if (m_fn[5]) v[5] = sclk_out[1] ^ m_lat[5];
      return v;
   endfunction

   function automatic logic [1:0] exp_rx();
      logic src0 = m_alt ? alt_rx0_i : pin_in[1];
      return {pin_in[4] ^ m_lat[4], src0 ^ m_lat[1]};
   endfunction

   function automatic logic [1:0] exp_cts();
      return {pin_in[5] ^ m_lat[5], pin_in[2] ^ m_lat[2]};
   endfunction

   function automatic logic [W-1:0] exp_rd(input logic [1:0] a);
      case (a)
         2'd0:    return (m_lat & m_dir) | (pin_in & ~m_dir);
         2'd1:    return m_dir;
         2'd2:    return m_fn;
         default: return {{(W-1){1'b0}}, m_alt};
      endcase
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      #2;
      check("R4 pin_oe", pin_oe, m_dir);
      check("R5 R6 R10 pin_out", pin_out, exp_out());
      check("R7 R8 ch_rx", {4'b0, ch_rx}, {4'b0, exp_rx()});
      check("R9 ch_cts", {4'b0, ch_cts}, {4'b0, exp_cts()});
      check("R9 ch_sclk_in", {4'b0, ch_sclk_in}, {4'b0, exp_cts()});
      for (int a = 0; a < 4; a++) begin
         addr = 2'(a);
         #1;
         check(a == 0 ? "R3 data read" : "R2 register read", rdata, exp_rd(2'(a)));
      end
   endtask

   task automatic write_reg(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      case (a)
         2'd0: m_lat = d;
         2'd1: m_dir = d;
         2'd2: m_fn  = d;
         default: m_alt = d[0];
      endcase
   endtask

   task automatic set_inputs(input logic [W-1:0] p, input logic a, input logic [1:0] s);
      @(negedge clk);
      pin_in = p; alt_rx0_i = a; sclk_out = s;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset state, checked while reset is held and after release
      pin_in = 6'b101010;
      repeat (2) @(negedge clk);
      check_all();
      check("R1 latch reset", exp_out(), 6'b111111);
      rst_n = 1'b1;
      @(negedge clk);
      check_all();

      // R8: alternate receive select with and without inversion
      set_inputs(6'b000000, 1'b1, 2'b00);
      check_all();
      write_reg(2'd3, 6'b111111);
      check_all();
      write_reg(2'd0, 6'b000000);
      check_all();
      set_inputs(6'b000010, 1'b0, 2'b00);
      check_all();
      write_reg(2'd3, 6'b000000);
      check_all();

      // R6: clock driven out on pins 2 and 5, inverted and plain
      write_reg(2'd1, 6'b111111);
      write_reg(2'd2, 6'b100100);
      set_inputs(6'b000000, 1'b0, 2'b10);
      check_all();
      write_reg(2'd0, 6'b100000);
      check_all();

      // R10: function bits on the non-clock pins leave pin_out on the latch
      write_reg(2'd2, 6'b011011);
      write_reg(2'd0, 6'b010010);
      set_inputs(6'b111111, 1'b1, 2'b11);
      check_all();

      // R2 R3 R5 R7 R9: constrained random traffic
      for (int n = 0; n < 400; n++) begin
         logic [1:0] a = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 3) != 0)
            write_reg(a, W'($urandom));
         set_inputs(W'($urandom), 1'($urandom), 2'($urandom));
         check_all();
      end

      // R1: asynchronous reset in mid-run
      @(negedge clk);
      #2 rst_n = 1'b0;
      m_lat = '1; m_dir = '0; m_fn = '0; m_alt = 1'b0;
      check_all();
      @(negedge clk) rst_n = 1'b1;
      check_all();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule